// File: doc/BRIEF.md
# Static Memory Controller with Per-Device Timing

This block turns single requests from an internal bus (27-bit byte address, 32-bit write data, four byte enables, a read/write flag, and a valid/ready handshake) into cycles on an asynchronous external memory bus. That bus can serve up to eight devices such as flash or SRAM. The top three address bits select one of eight active-low device selects. The lower 24 bits address up to 16 MB inside the selected device.

Every device select has its own configuration word, written through a small configuration port. The word sets the external bus width (8 or 16 bits) and four 4-bit timing counts in system clocks: setup, wait states, hold and float. A 32-bit request is broken into one external cycle per enabled byte (8-bit bus) or one per enabled halfword (16-bit bus). Each external cycle runs through setup, strobe and hold. An active-low wait input from the device stretches the strobe. Read bytes are put back together little-endian. The internal bus sees ready only once, after the last external cycle. After each access, a float interval keeps a different device from being selected too soon.

Top module: `statmem_bridge`

## Requirements
- R1: After reset all device selects, the read strobe and both write strobes are high, the data-drive enable is low, ready is low and the read data is zero.
- R2: During an access exactly one device select is low: the one numbered by reqAddr[26:24]. It stays low from the first setup clock to the last hold clock. memAddr[23:2] equals reqAddr[23:2].
- R3: Each external cycle begins with exactly S setup clocks, in which the device select is low and all strobes are high. S is the setup field; S = 0 gives no setup clock.
- R4: The strobe phase lasts W+1 clocks when wait is not asserted, where W is the wait-state field. A read pulls memRdN low; a write pulls write strobes low.
- R5: While memWaitN is low in the last counted strobe clock, the strobe phase goes on. It ends at the first clock whose count has run out and in which memWaitN is high.
- R6: After the strobe come exactly H hold clocks, in which strobes are high and the device select and address are unchanged. H is the hold field.
- R7: On an 8-bit bus, each enabled byte lane gets one external cycle, in ascending lane order. memAddr[1:0] equals the lane, the byte is on memDout[7:0]/memDin[7:0], and a write pulls only memWrN[0]. A request with no byte enables is one byte at lane reqAddr[1:0].
- R8: On a 16-bit bus, each halfword with any enabled byte gets one external cycle, in ascending order. memAddr[0] is 0 and memAddr[1] selects the halfword. A write pulls memWrN[0] only if the even lane is enabled and memWrN[1] only if the odd lane is enabled.
- R9: Read data is sampled in the last strobe clock and placed little-endian: byte lane n in reqRdata[8n+7:8n], and a 16-bit sub-read fills two lanes. Lanes that were not read return zero.
- R10: reqReady is high for exactly one clock, directly after the last clock of the last external cycle. All device selects are then high. reqRdata holds until the next access starts.
- R11: After an access to device c, a request to another device is not started until F idle clocks have passed, and never in the ready clock. F is the float field of c. A request to the same device waits only for the ready clock.
- R12: memOe is high throughout a write access (setup to hold) and low otherwise. memDout carries the write byte or halfword of the current sub-cycle.
- R13: A configuration write with cfgWe high stores cfgWdata for device cfgSel. The layout is bit 16 = 16-bit bus, [15:12] setup, [11:8] wait states, [7:4] hold, [3:0] float. The new value governs the next access to that device. Reset value is all zero (8-bit, no setup/hold/float, one strobe clock).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWe | input | 1 | Configuration write enable |
| cfgSel | input | 3 | Device select whose configuration is written |
| cfgWdata | input | 17 | Configuration word |
| reqValid | input | 1 | Request valid, held until ready |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 27 | Byte address, top 3 bits pick the device |
| reqWdata | input | 32 | Write data, little-endian lanes |
| reqBe | input | 4 | Byte enables |
| reqReady | output | 1 | One-clock completion pulse |
| reqRdata | output | 32 | Assembled read data |
| memCsN | output | 8 | Active-low device selects |
| memAddr | output | 24 | External address |
| memDout | output | 16 | External write data |
| memOe | output | 1 | Drive enable for memDout |
| memDin | input | 16 | External read data |
| memRdN | output | 1 | Active-low read strobe |
| memWrN | output | 2 | Active-low write strobes, [1] high byte, [0] low byte |
| memWaitN | input | 1 | Active-low stall from the device |

## Verification
The bench goes after the counter edges:

- A zero setup or hold count must add no clock. A design that loaded the count without subtracting one would stretch every phase by a clock.
- A wait stall that begins exactly as the wait-state count expires must extend the strobe. If the stall were sampled only while counting, the read would be captured early with stale data.
- Partial byte enables must be split correctly. A request that straddles both halfwords on a 16-bit bus, or one with sparse lanes on an 8-bit bus, would show a wrong lane order, a wrong write strobe or stray non-zero read bytes.
- Back-to-back requests to different devices must respect the float interval. A design that got this wrong would assert the next select during the previous device's float time, or would also delay same-device requests.

// File: rtl/statmem_pkg.sv
package statmem_pkg;
  localparam int TIME_W = 4;
  localparam int LANES  = 4;
  localparam int LANE_W = 2;

  typedef struct packed {
    logic              wide;
    logic [TIME_W-1:0] setup;
    logic [TIME_W-1:0] waitSt;
    logic [TIME_W-1:0] hold;
    logic [TIME_W-1:0] flt;
  } csCfgT;

  localparam int CFG_W = $bits(csCfgT);

  typedef struct packed {
    logic              capture;
    logic              sample;
    logic              active;
    logic              isWrite;
    logic              rdStb;
    logic              wrStb;
    logic              wide;
    logic [LANE_W-1:0] lane;
  } dpCtlT;
endpackage

// File: rtl/statmem_cfg.sv
module statmem_cfg
  import statmem_pkg::*;
#(
  parameter int NUM_CS = 8,
  parameter int CS_W   = $clog2(NUM_CS)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     cfgWe,
  input  logic [CS_W-1:0]          cfgSel,
  input  csCfgT                    cfgWdata,
  output csCfgT [NUM_CS-1:0]       cfgAll
);
  for (genvar g = 0; g < NUM_CS; g++) begin : gCsReg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                               cfgAll[g] <= '0;
      else if (cfgWe && cfgSel == CS_W'(g))    cfgAll[g] <= cfgWdata;
    end
  end
endmodule

// File: rtl/statmem_fsm.sv
module statmem_fsm
  import statmem_pkg::*;
#(
  parameter int NUM_CS = 8,
  parameter int CS_W   = $clog2(NUM_CS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic                reqWrite,
  input  logic [CS_W-1:0]     reqCs,
  input  logic [LANE_W-1:0]   reqLane,
  input  logic [LANES-1:0]    reqBe,
  input  csCfgT [NUM_CS-1:0]  cfgAll,
  input  logic                memWaitN,
  output dpCtlT               ctl,
  output logic                reqReady,
  output logic [CS_W-1:0]     curCs
);
  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_STROBE, PH_HOLD} phaseT;

  phaseT             phase;
  logic [TIME_W-1:0] cnt, floatCnt;
  logic [LANES-1:0]  mask, usedMask, restMask;
  logic [LANE_W-1:0] lane;
  logic [CS_W-1:0]   lastCs;
  logic              isWr;
  csCfgT             curCfg;
  logic              accept, strobeDone, holdDone, subEnd;

  assign curCfg = cfgAll[curCs];

  always_comb begin
    lane = '0;
    if (curCfg.wide) begin
      lane = (mask[1:0] != 2'b00) ? 2'd0 : 2'd2;
      usedMask = 4'b0011 << lane;
    end else begin
      for (int i = LANES - 1; i >= 0; i--)
        if (mask[i]) lane = LANE_W'(i);
      usedMask = 4'b0001 << lane;
    end
    restMask = mask & ~usedMask;
  end

  assign accept     = (phase == PH_IDLE) && reqValid && !reqReady &&
                      ((floatCnt == '0) || (reqCs == lastCs));
  assign strobeDone = (phase == PH_STROBE) && (cnt == '0) && memWaitN;
  assign holdDone   = (phase == PH_HOLD) && (cnt == '0);
  assign subEnd     = (strobeDone && curCfg.hold == '0) || holdDone;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      cnt      <= '0;
      floatCnt <= '0;
      mask     <= '0;
      isWr     <= 1'b0;
      curCs    <= '0;
      lastCs   <= '0;
      reqReady <= 1'b0;
    end else begin
      reqReady <= subEnd && (restMask == '0);
      case (phase)
        PH_IDLE: begin
          if (floatCnt != '0) floatCnt <= floatCnt - 1'b1;
          if (accept) begin
            curCs <= reqCs;
            isWr  <= reqWrite;
            mask  <= (reqBe == '0) ? (LANES'(1) << reqLane) : reqBe;
            if (cfgAll[reqCs].setup != '0) begin
              phase <= PH_SETUP;
              cnt   <= cfgAll[reqCs].setup - 1'b1;
            end else begin
              phase <= PH_STROBE;
              cnt   <= cfgAll[reqCs].waitSt;
            end
          end
        end
        PH_SETUP: begin
          if (cnt == '0) begin
            phase <= PH_STROBE;
            cnt   <= curCfg.waitSt;
          end else cnt <= cnt - 1'b1;
        end
        PH_STROBE: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else if (memWaitN && curCfg.hold != '0) begin
            phase <= PH_HOLD;
            cnt   <= curCfg.hold - 1'b1;
          end
        end
        default: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
        end
      endcase
      if (subEnd) begin
        if (restMask == '0) begin
          phase    <= PH_IDLE;
          floatCnt <= curCfg.flt;
          lastCs   <= curCs;
        end else begin
          mask <= restMask;
          if (curCfg.setup != '0) begin
            phase <= PH_SETUP;
            cnt   <= curCfg.setup - 1'b1;
          end else begin
            phase <= PH_STROBE;
            cnt   <= curCfg.waitSt;
          end
        end
      end
    end
  end

  always_comb begin
    ctl.capture = accept;
    ctl.sample  = strobeDone && !isWr;
    ctl.active  = (phase != PH_IDLE);
    ctl.isWrite = isWr;
    ctl.rdStb   = (phase == PH_STROBE) && !isWr;
    ctl.wrStb   = (phase == PH_STROBE) && isWr;
    ctl.wide    = curCfg.wide;
    ctl.lane    = lane;
  end

  // R5: an asserted wait in the final counted strobe clock keeps the strobe
  a_r5_wait_extends: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_STROBE && cnt == '0 && !memWaitN) |=> (phase == PH_STROBE));

  // R11: a pending float interval blocks a different device
  a_r11_float_blocks: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_IDLE && floatCnt != '0 && reqCs != lastCs) |=> (phase == PH_IDLE));

  // R10: ready is a single-clock pulse
  a_r10_ready_pulse: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |=> !reqReady);

  // R10: ready only follows a finished access
  a_r10_ready_after_access: assert property (@(posedge clk) disable iff (!rstN)
    $rose(reqReady) |-> $past(phase != PH_IDLE));
endmodule

// File: rtl/statmem_dp.sv
module statmem_dp
  import statmem_pkg::*;
#(
  parameter int NUM_CS = 8,
  parameter int DEV_W  = 24,
  parameter int CS_W   = $clog2(NUM_CS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dpCtlT                ctl,
  input  logic [CS_W-1:0]      curCs,
  input  logic [DEV_W-1:2]     reqWordAddr,
  input  logic [31:0]          reqWdata,
  input  logic [LANES-1:0]     reqBe,
  input  logic [15:0]          memDin,
  output logic [DEV_W-1:0]     memAddr,
  output logic [15:0]          memDout,
  output logic                 memOe,
  output logic [NUM_CS-1:0]    memCsN,
  output logic                 memRdN,
  output logic [1:0]           memWrN,
  output logic [31:0]          reqRdata
);
  logic [DEV_W-1:2] addrQ;
  logic [31:0]      wdataQ, rdataQ;
  logic [LANES-1:0] beQ;
  logic [4:0]       byteBase, halfBase;

  assign byteBase = {ctl.lane, 3'b000};
  assign halfBase = {ctl.lane[1], 4'b0000};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      beQ    <= '0;
      rdataQ <= '0;
    end else if (ctl.capture) begin
      addrQ  <= reqWordAddr;
      wdataQ <= reqWdata;
      beQ    <= reqBe;
      rdataQ <= '0;
    end else if (ctl.sample) begin
      if (ctl.wide) rdataQ[halfBase +: 16] <= memDin;
      else          rdataQ[byteBase +: 8]  <= memDin[7:0];
    end
  end

  assign memAddr  = {addrQ, ctl.lane};
  assign memCsN   = ctl.active ? ~(NUM_CS'(1) << curCs) : '1;
  assign memOe    = ctl.active && ctl.isWrite;
  assign memDout  = ctl.wide ? wdataQ[halfBase +: 16] : {8'h00, wdataQ[byteBase +: 8]};
  assign memRdN   = !ctl.rdStb;
  assign memWrN   = ctl.wide ? {!(ctl.wrStb && beQ[{ctl.lane[1], 1'b1}]),
                                !(ctl.wrStb && beQ[{ctl.lane[1], 1'b0}])}
                             : {1'b1, !ctl.wrStb};
  assign reqRdata = rdataQ;

  // R2: never more than one device selected
  a_r2_single_select: assert property (@(posedge clk) disable iff (!rstN)
    $countones(~memCsN) <= 1);

  // R12: the bus is not driven while a read strobe is low
  a_r12_no_drive_on_read: assert property (@(posedge clk) disable iff (!rstN)
    !memRdN |-> !memOe);

  // R4: read and write strobes never overlap
  a_r4_strobe_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    (memWrN != 2'b11) |-> memRdN);

  // R2: address stays put while the strobe is held by wait
  a_r2_addr_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!memRdN && $past(!memRdN) && $past(ctl.active)) |-> $stable(memAddr[DEV_W-1:2]));
endmodule

// File: rtl/statmem_bridge.sv
module statmem_bridge
  import statmem_pkg::*;
#(
  parameter int NUM_CS = 8,
  parameter int DEV_W  = 24,
  localparam int CS_W  = $clog2(NUM_CS),
  localparam int REQ_W = DEV_W + CS_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [CS_W-1:0]   cfgSel,
  input  logic [CFG_W-1:0]  cfgWdata,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [REQ_W-1:0]  reqAddr,
  input  logic [31:0]       reqWdata,
  input  logic [LANES-1:0]  reqBe,
  output logic              reqReady,
  output logic [31:0]       reqRdata,
  output logic [NUM_CS-1:0] memCsN,
  output logic [DEV_W-1:0]  memAddr,
  output logic [15:0]       memDout,
  output logic              memOe,
  input  logic [15:0]       memDin,
  output logic              memRdN,
  output logic [1:0]        memWrN,
  input  logic              memWaitN
);
  csCfgT [NUM_CS-1:0] cfgAll;
  dpCtlT              ctl;
  logic [CS_W-1:0]    curCs;

  statmem_cfg #(.NUM_CS(NUM_CS)) cfg_i (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel),
    .cfgWdata(csCfgT'(cfgWdata)), .cfgAll(cfgAll));

  statmem_fsm #(.NUM_CS(NUM_CS)) fsm_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqCs(reqAddr[REQ_W-1:DEV_W]), .reqLane(reqAddr[1:0]), .reqBe(reqBe),
    .cfgAll(cfgAll), .memWaitN(memWaitN), .ctl(ctl), .reqReady(reqReady),
    .curCs(curCs));

  statmem_dp #(.NUM_CS(NUM_CS), .DEV_W(DEV_W)) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .curCs(curCs),
    .reqWordAddr(reqAddr[DEV_W-1:2]), .reqWdata(reqWdata), .reqBe(reqBe),
    .memDin(memDin), .memAddr(memAddr), .memDout(memDout), .memOe(memOe),
    .memCsN(memCsN), .memRdN(memRdN), .memWrN(memWrN), .reqRdata(reqRdata));
endmodule

// File: tb/statmem_bridge_tb_top.sv
module statmem_bridge_tb_top;
  logic        clk = 1'b0;
  logic        rstN;
  logic        cfgWe;
  logic [2:0]  cfgSel;
  logic [16:0] cfgWdata;
  logic        reqValid, reqWrite;
  logic [26:0] reqAddr;
  logic [31:0] reqWdata;
  logic [3:0]  reqBe;
  logic        reqReady;
  logic [31:0] reqRdata;
  logic [7:0]  memCsN;
  logic [23:0] memAddr;
  logic [15:0] memDout, memDin;
  logic        memOe, memRdN, memWaitN;
  logic [1:0]  memWrN;

  always #10 clk = ~clk;

  // device model: read data is a function of the address
  assign memDin = {memAddr[7:0] ^ 8'hA5, memAddr[7:0]};

  statmem_bridge dut_i (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgWdata(cfgWdata),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .reqBe(reqBe), .reqReady(reqReady), .reqRdata(reqRdata), .memCsN(memCsN),
    .memAddr(memAddr), .memDout(memDout), .memOe(memOe), .memDin(memDin),
    .memRdN(memRdN), .memWrN(memWrN), .memWaitN(memWaitN));

  typedef struct {
    logic [7:0]  csN;
    logic        rdN;
    logic [1:0]  wrN;
    logic        oe;
    logic        rdy;
    logic        chkAddr;
    logic [23:0] addr;
    logic        chkDout;
    logic [15:0] dout;
    logic        waitN;
    int          tag;
  } expT;

  expT q[$];
  int  checks = 0, errors = 0, cyc = 0;
  int  cS[8], cW[8], cH[8], cF[8];
  bit  cWide[8];
  bit  rdyBlk = 0;
  int  fl = 0, lastCs = 0;

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than 50000", cyc);
      finishRun();
    end
  end

  task automatic chk(bit ok, int tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic expT idleE(int tag);
    expT e;
    e.csN = 8'hFF; e.rdN = 1'b1; e.wrN = 2'b11; e.oe = 1'b0; e.rdy = 1'b0;
    e.chkAddr = 1'b0; e.addr = '0; e.chkDout = 1'b0; e.dout = '0;
    e.waitN = 1'b1; e.tag = tag;
    return e;
  endfunction

  task automatic stepIdle();
    @(negedge clk);
    rdyBlk = 0;
    if (fl > 0) fl--;
  endtask

  // R13: configuration word layout {wide, setup, wait, hold, float}
  task automatic setCfg(int cs, bit wide, int s, int w, int h, int f);
    cfgWe = 1'b1; cfgSel = 3'(cs);
    cfgWdata = {wide, 4'(s), 4'(w), 4'(h), 4'(f)};
    stepIdle();
    cfgWe = 1'b0;
    cS[cs] = s; cW[cs] = w; cH[cs] = h; cF[cs] = f; cWide[cs] = wide;
  endtask

  task automatic runAccess(bit wr, logic [26:0] a, logic [31:0] wd, logic [3:0] be, int stall);
    int cs;
    int lanes[$];
    logic [3:0] eb;
    logic [23:0] devA;
    logic [31:0] expRd;
    expT e;
    cs = int'(a[26:24]);
    eb = (be == 4'b0) ? (4'b0001 << a[1:0]) : be;
    expRd = '0;
    while (rdyBlk || (fl != 0 && cs != lastCs)) begin
      q.push_back(idleE(11));
      rdyBlk = 0;
      if (fl > 0) fl--;
    end
    if (cWide[cs]) begin
      for (int h = 0; h < 2; h++) if (eb[2*h] || eb[2*h+1]) lanes.push_back(2*h);
    end else begin
      for (int l = 0; l < 4; l++) if (eb[l]) lanes.push_back(l);
    end
    foreach (lanes[k]) begin
      int l;
      l = lanes[k];
      devA = {a[23:2], 2'(l)};
      e = idleE(3);
      e.csN = ~(8'h01 << cs); e.oe = wr; e.chkAddr = 1'b1; e.addr = devA;
      e.chkDout = wr;
      e.dout = cWide[cs] ? wd[16*(l/2) +: 16] : {8'h00, wd[8*l +: 8]};
      for (int i = 0; i < cS[cs]; i++) q.push_back(e);
      for (int i = 0; i < cW[cs] + 1 + stall; i++) begin
        e.rdN = wr ? 1'b1 : 1'b0;
        e.wrN = !wr ? 2'b11 : (cWide[cs] ? {~eb[l+1], ~eb[l]} : 2'b10);
        e.waitN = (stall > 0 && i < cW[cs] + stall) ? 1'b0 : 1'b1;
        e.tag = (stall > 0) ? 5 : (cW[cs] > 0) ? 4 : cWide[cs] ? 8 : 7;
        q.push_back(e);
      end
      if (!wr) begin
        if (cWide[cs]) expRd[16*(l/2) +: 16] = {devA[7:0] ^ 8'hA5, devA[7:0]};
        else           expRd[8*l +: 8] = devA[7:0];
      end
      e.rdN = 1'b1; e.wrN = 2'b11; e.waitN = 1'b1; e.tag = 6;
      for (int i = 0; i < cH[cs]; i++) q.push_back(e);
    end
    e = idleE(10);
    e.rdy = 1'b1;
    q.push_back(e);
    rdyBlk = 1; fl = cF[cs]; lastCs = cs;

    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = wd; reqBe = be;
    while (q.size() > 0) begin
      e = q.pop_front();
      @(negedge clk);
      chk({memCsN, memRdN, memWrN, memOe, reqReady} == {e.csN, e.rdN, e.wrN, e.oe, e.rdy},
          e.tag, "select/strobes/oe/ready",
          longint'({memCsN, memRdN, memWrN, memOe, reqReady}),
          longint'({e.csN, e.rdN, e.wrN, e.oe, e.rdy}));
      if (e.chkAddr) chk(memAddr == e.addr, 2, "address", longint'(memAddr), longint'(e.addr));
      if (e.chkDout) chk(memDout == e.dout, 12, "write data", longint'(memDout), longint'(e.dout));
      memWaitN = e.waitN;
    end
    if (!wr) chk(reqRdata == expRd, 9, "read data", longint'(reqRdata), longint'(expRd));
    reqValid = 1'b0;
  endtask

  initial begin
    rstN = 1'b0; cfgWe = 1'b0; cfgSel = '0; cfgWdata = '0;
    reqValid = 1'b0; reqWrite = 1'b0; reqAddr = '0; reqWdata = '0; reqBe = '0;
    memWaitN = 1'b1;
    for (int i = 0; i < 8; i++) begin
      cS[i] = 0; cW[i] = 0; cH[i] = 0; cF[i] = 0; cWide[i] = 0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: idle pins after reset
    chk({memCsN, memRdN, memWrN, memOe, reqReady} == {8'hFF, 1'b1, 2'b11, 1'b0, 1'b0}, 1,
        "reset pins", longint'({memCsN, memRdN, memWrN, memOe, reqReady}),
        longint'({8'hFF, 1'b1, 2'b11, 1'b0, 1'b0}));
    chk(reqRdata == '0, 1, "reset read data", longint'(reqRdata), 0);
    @(negedge clk);

    setCfg(1, 1'b1, 2, 1, 1, 3);
    setCfg(2, 1'b0, 1, 2, 0, 0);
    setCfg(7, 1'b1, 0, 0, 2, 5);

    // R7: default narrow device, full word write then read
    runAccess(1'b1, {3'd0, 24'h000100}, 32'hDDCCBBAA, 4'hF, 0);
    runAccess(1'b0, {3'd0, 24'h000104}, 32'h0, 4'hF, 0);
    // R3 R4 R6 R8 R9: wide device with setup, wait and hold
    runAccess(1'b0, {3'd1, 24'h123450}, 32'h0, 4'hF, 0);
    runAccess(1'b1, {3'd1, 24'h123454}, 32'h44332211, 4'b0110, 0);
    // R11: different device right after a float of 3
    runAccess(1'b0, {3'd2, 24'h00ABC8}, 32'h0, 4'b1010, 0);
    // R5: stall on the same device, no float wait
    runAccess(1'b0, {3'd2, 24'h00ABCC}, 32'h0, 4'b0001, 3);
    runAccess(1'b1, {3'd2, 24'h00ABD0}, 32'h0000EE00, 4'b0010, 1);
    // R2: highest device, wide write of upper half with stall
    runAccess(1'b1, {3'd7, 24'hFEDCB8}, 32'h87654321, 4'b1100, 2);
    // R11: float of 5 before device 0
    runAccess(1'b0, {3'd0, 24'h000200}, 32'h0, 4'b0100, 0);
    // R7: no byte enables means one byte at the addressed lane
    runAccess(1'b1, {3'd0, 24'h000207}, 32'h5A000000, 4'b0000, 0);
    // R13: reconfigure device 0 as wide with setup, new timing takes effect
    setCfg(0, 1'b1, 1, 0, 0, 0);
    runAccess(1'b0, {3'd0, 24'h000208}, 32'h0, 4'hF, 0);
    runAccess(1'b1, {3'd0, 24'h00020C}, 32'h0000BEEF, 4'b0011, 0);
    repeat (3) @(negedge clk);
    finishRun();
  end
endmodule